// File: doc/BRIEF.md
# Dual-Direction Inter-Processor Mailbox

This block is a register-level mailbox that sits between an application processor (side A) and a system-control microcontroller (side B). Each side has its own APB-style register port. The block offers a parameterised number of independent channels in each direction. The sending side first writes a command word and then a data word into a channel slot. The write of the data word raises that channel's pending bit. When the matching enable bit is set, the pending bit drives a level interrupt into the receiving side. The receiver reads both words and then acknowledges by writing a one to the pending bit.

A small bank of lock slots provides mutual exclusion between the two processors. A read of a free slot returns 0 and claims the slot in the same access. A read of a held slot returns 1. A write of any value to a slot frees it. The payload memory and the meaning of the words are outside this block.

Each port uses a setup cycle (select high, enable low) followed by an access cycle (select and enable high). Read data is valid during the access cycle. Writes and lock claims take effect at the clock edge that ends the access cycle.

Top module: `mbx_dual_top`

## Requirements
- R1: After reset, every command, data, enable and status register reads 0, both interrupt vectors are 0, and every lock slot is free.
- R2: The address map is as follows. A-to-B enable is at 0x00, A-to-B status at 0x04, A-to-B command of channel x at 0x08+8x and A-to-B data of channel x at 0x0C+8x. B-to-A enable is at 0x28, B-to-A status at 0x2C, B-to-A command at 0x30+8x and B-to-A data at 0x34+8x. Bit x of an enable or status register belongs to channel x.
- R3: A sender write to a channel's data word sets that channel's status bit in that direction. A write to the command word alone leaves the status bits unchanged.
- R4: The receiving side clears a status bit by writing 1 to that bit. A written 0 leaves the bit as it was. When a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: For each direction, interrupt bit x (irq_b for A-to-B, irq_a for B-to-A) is high exactly while status bit x and enable bit x are both 1. It is a level and falls only through a clear or an enable change.
- R6: Only side A can write the A-to-B command and data words, and only side B can write the B-to-A ones. Enable and status of a direction are writable only by its receiving side. Writes from the other side have no effect.
- R7: Both sides can read every command, data, enable and status register of both directions.
- R8: Command and data words hold the last value that their owner wrote.
- R9: Lock slot k is at 0x100+8k. A read of a free slot returns 0 and claims the slot. A read of a held slot returns 1. A write of any value from either side frees the slot.
- R10: When both sides read the same free lock slot in the same cycle, side A receives 0 and holds the slot, and side B receives 1.
- R11: Reads of unmapped or unaligned offsets return 0. Writes to them change no register and no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_psel | input | 1 | Side A select |
| a_penable | input | 1 | Side A access phase |
| a_pwrite | input | 1 | Side A write (1) or read (0) |
| a_paddr | input | ADDR_W | Side A byte offset |
| a_pwdata | input | DATA_W | Side A write data |
| a_prdata | output | DATA_W | Side A read data, valid in the access phase |
| b_psel | input | 1 | Side B select |
| b_penable | input | 1 | Side B access phase |
| b_pwrite | input | 1 | Side B write (1) or read (0) |
| b_paddr | input | ADDR_W | Side B byte offset |
| b_pwdata | input | DATA_W | Side B write data |
| b_prdata | output | DATA_W | Side B read data, valid in the access phase |
| irq_a | output | NUM_CH | Per-channel B-to-A interrupt levels toward side A |
| irq_b | output | NUM_CH | Per-channel A-to-B interrupt levels toward side B |

## Verification
The bench builds the block with its defaults: four channels, four lock slots, a 12-bit offset and 32-bit words. With these values the highest channel's data word at 0x4C sits next to the unmapped offset 0x50, and both interior and edge channels can be reached. Each slot of the lock bank can also be reached. Two cases need both ports driven in the same cycle: the collision between a data write and a status clear, and the race of two reads on one lock slot. The bench drives these cases with two concurrent drivers.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Spacing between per-channel register pairs and the lock slots
  localparam int unsigned SLOT_STRIDE = 8;
  // Enable and status occupy the first two words of each direction
  localparam int unsigned CH_FIRST    = 8;
  localparam int unsigned LOCK_BASE   = 'h100;

  function automatic int unsigned dir_span(input int unsigned nch);
    return CH_FIRST + SLOT_STRIDE * nch;
  endfunction

  function automatic int unsigned cmd_off(input int unsigned base, input int unsigned ch);
    return base + CH_FIRST + SLOT_STRIDE * ch;
  endfunction

  function automatic int unsigned dat_off(input int unsigned base, input int unsigned ch);
    return base + CH_FIRST + SLOT_STRIDE * ch + 4;
  endfunction

  function automatic int unsigned lock_off(input int unsigned k);
    return LOCK_BASE + SLOT_STRIDE * k;
  endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_dir.sv
// One message direction: per-channel command/data words, pending status,
// interrupt enables and per-channel interrupt levels.
module mbx_dir #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 12,
  parameter int unsigned BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snd_wr,
  input  logic [AW-1:0] snd_addr,
  input  logic [DW-1:0] snd_wdata,
  input  logic          rcv_wr,
  input  logic [AW-1:0] rcv_addr,
  input  logic [NCH-1:0] rcv_wdata,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  output logic [NCH-1:0] irq
);
  import mbx_pkg::*;

  localparam logic [AW-1:0] EN_ADR = AW'(BASE);
  localparam logic [AW-1:0] ST_ADR = AW'(BASE + 4);

  logic [NCH-1:0][DW-1:0] cmd_q, dat_q;
  logic [NCH-1:0][AW-1:0] cmd_adr, dat_adr;
  logic [NCH-1:0]         cmd_we, dat_we;
  logic [NCH-1:0]         st_q, st_d, en_q, en_d, clr_v;
  logic                   en_we, st_we;

  // Address decode
  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    localparam logic [AW-1:0] CA = AW'(cmd_off(BASE, ch));
    localparam logic [AW-1:0] DA = AW'(dat_off(BASE, ch));
    assign cmd_adr[ch] = CA;
    assign dat_adr[ch] = DA;
    assign cmd_we[ch]  = snd_wr && (snd_addr == CA);
    assign dat_we[ch]  = snd_wr && (snd_addr == DA);
  end

  assign en_we = rcv_wr && (rcv_addr == EN_ADR);
  assign st_we = rcv_wr && (rcv_addr == ST_ADR);

  // Next state: a new message beats an acknowledge in the same cycle
  always_comb begin
    clr_v = st_we ? rcv_wdata : '0;
    st_d  = (st_q & ~clr_v) | dat_we;
    en_d  = en_we ? rcv_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      dat_q <= '0;
      st_q  <= '0;
      en_q  <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (cmd_we[ch]) cmd_q[ch] <= snd_wdata;
        if (dat_we[ch]) dat_q[ch] <= snd_wdata;
      end
      if (st_we || (|dat_we)) st_q <= st_d;
      if (en_we)              en_q <= en_d;
    end
  end

  assign irq = st_q & en_q;

  function automatic logic [DW-1:0] pick(
    input logic [AW-1:0]          ad,
    input logic [NCH-1:0]         en_v,
    input logic [NCH-1:0]         st_v,
    input logic [NCH-1:0][DW-1:0] cmd_v,
    input logic [NCH-1:0][DW-1:0] dat_v,
    input logic [NCH-1:0][AW-1:0] cadr,
    input logic [NCH-1:0][AW-1:0] dadr
  );
    logic [DW-1:0] r;
    r = '0;
    if (ad == EN_ADR) r[NCH-1:0] = en_v;
    if (ad == ST_ADR) r[NCH-1:0] = st_v;
    for (int ch = 0; ch < NCH; ch++) begin
      if (ad == cadr[ch]) r = cmd_v[ch];
      if (ad == dadr[ch]) r = dat_v[ch];
    end
    return r;
  endfunction

  assign rd_data_a = pick(rd_addr_a, en_q, st_q, cmd_q, dat_q, cmd_adr, dat_adr);
  assign rd_data_b = pick(rd_addr_b, en_q, st_q, cmd_q, dat_q, cmd_adr, dat_adr);
endmodule

// File: rtl/mbx_locks.sv
// Bank of test-and-set slots shared by both ports; side A wins a tie.
module mbx_locks #(
  parameter int unsigned NLK = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] a_rdata,
  output logic [DW-1:0] b_rdata
);
  import mbx_pkg::*;

  logic [NLK-1:0] lk_q, lk_d, lk_we;
  logic [NLK-1:0] a_hit, b_hit, a_take, b_take, rel;

  for (genvar k = 0; k < NLK; k++) begin : g_dec
    localparam logic [AW-1:0] LA = AW'(lock_off(k));
    assign a_hit[k] = (a_addr == LA);
    assign b_hit[k] = (b_addr == LA);
  end

  always_comb begin
    a_take = a_rd ? (a_hit & ~lk_q) : '0;
    b_take = b_rd ? (b_hit & ~lk_q & ~a_take) : '0;
    rel    = (a_wr ? a_hit : '0) | (b_wr ? b_hit : '0);
    lk_d   = (lk_q & ~rel) | a_take | b_take;
    lk_we  = rel | a_take | b_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q <= '0;
    end else begin
      for (int k = 0; k < NLK; k++) begin
        if (lk_we[k]) lk_q[k] <= lk_d[k];
      end
    end
  end

  assign a_rdata = DW'(|(a_hit & lk_q));
  assign b_rdata = DW'(|(b_hit & (lk_q | a_take)));
endmodule

// File: rtl/mbx_dual_top.sv
module mbx_dual_top #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned NUM_LOCK = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_psel,
  input  logic              a_penable,
  input  logic              a_pwrite,
  input  logic [ADDR_W-1:0] a_paddr,
  input  logic [DATA_W-1:0] a_pwdata,
  output logic [DATA_W-1:0] a_prdata,
  input  logic              b_psel,
  input  logic              b_penable,
  input  logic              b_pwrite,
  input  logic [ADDR_W-1:0] b_paddr,
  input  logic [DATA_W-1:0] b_pwdata,
  output logic [DATA_W-1:0] b_prdata,
  output logic [NUM_CH-1:0] irq_a,
  output logic [NUM_CH-1:0] irq_b
);
  import mbx_pkg::*;

  localparam int unsigned A2B_BASE = 0;
  localparam int unsigned B2A_BASE = dir_span(NUM_CH);

  logic rst_q_n;
  logic a_wr, a_rd, b_wr, b_rd;
  logic [DATA_W-1:0] ab_ra, ab_rb, ba_ra, ba_rb, lk_ra, lk_rb;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  assign a_wr = a_psel && a_penable && a_pwrite;
  assign a_rd = a_psel && a_penable && !a_pwrite;
  assign b_wr = b_psel && b_penable && b_pwrite;
  assign b_rd = b_psel && b_penable && !b_pwrite;

  // A sends, B acknowledges
  mbx_dir #(.NCH(NUM_CH), .DW(DATA_W), .AW(ADDR_W), .BASE(A2B_BASE)) u_a2b (
    .clk(clk), .rst_n(rst_q_n),
    .snd_wr(a_wr), .snd_addr(a_paddr), .snd_wdata(a_pwdata),
    .rcv_wr(b_wr), .rcv_addr(b_paddr), .rcv_wdata(b_pwdata[NUM_CH-1:0]),
    .rd_addr_a(a_paddr), .rd_addr_b(b_paddr),
    .rd_data_a(ab_ra), .rd_data_b(ab_rb),
    .irq(irq_b)
  );

  // B sends, A acknowledges
  mbx_dir #(.NCH(NUM_CH), .DW(DATA_W), .AW(ADDR_W), .BASE(B2A_BASE)) u_b2a (
    .clk(clk), .rst_n(rst_q_n),
    .snd_wr(b_wr), .snd_addr(b_paddr), .snd_wdata(b_pwdata),
    .rcv_wr(a_wr), .rcv_addr(a_paddr), .rcv_wdata(a_pwdata[NUM_CH-1:0]),
    .rd_addr_a(a_paddr), .rd_addr_b(b_paddr),
    .rd_data_a(ba_ra), .rd_data_b(ba_rb),
    .irq(irq_a)
  );

  mbx_locks #(.NLK(NUM_LOCK), .DW(DATA_W), .AW(ADDR_W)) u_lk (
    .clk(clk), .rst_n(rst_q_n),
    .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_paddr),
    .b_rd(b_rd), .b_wr(b_wr), .b_addr(b_paddr),
    .a_rdata(lk_ra), .b_rdata(lk_rb)
  );

  assign a_prdata = a_rd ? (ab_ra | ba_ra | lk_ra) : '0;
  assign b_prdata = b_rd ? (ab_rb | ba_rb | lk_rb) : '0;
endmodule

// File: rtl/mbx_chk.sv
module mbx_dir_chk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned AW   = 12,
  parameter int unsigned BASE = 0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           snd_wr,
  input logic [AW-1:0]  snd_addr,
  input logic           rcv_wr,
  input logic [AW-1:0]  rcv_addr,
  input logic [NCH-1:0] rcv_wdata,
  input logic [NCH-1:0] st_q,
  input logic [NCH-1:0] irq
);
  logic rcv_ctl;
  logic rcv_clr_wr;
  assign rcv_clr_wr = rcv_wr && (rcv_addr == AW'(BASE + 4));
  assign rcv_ctl    = rcv_wr && ((rcv_addr == AW'(BASE)) || rcv_clr_wr);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0 && st_q == '0)); // R1

  for (genvar x = 0; x < NCH; x++) begin : g_ch
    AST_DATA_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_wr && snd_addr == AW'(BASE + 12 + 8 * x)) |=> st_q[x]); // R3

    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[x] && !(rcv_clr_wr && rcv_wdata[x])) |=> st_q[x]); // R4

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[x]) |-> $past(rcv_ctl)); // R5
  end
endmodule

module mbx_lock_chk #(
  parameter int unsigned NLK = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           a_rd,
  input logic           a_wr,
  input logic [AW-1:0]  a_addr,
  input logic           b_rd,
  input logic           b_wr,
  input logic [AW-1:0]  b_addr,
  input logic [DW-1:0]  a_rdata,
  input logic [DW-1:0]  b_rdata,
  input logic [NLK-1:0] lk_q
);
  for (genvar k = 0; k < NLK; k++) begin : g_lk
    logic ah, bh;
    assign ah = (a_addr == AW'(256 + 8 * k));
    assign bh = (b_addr == AW'(256 + 8 * k));

    AST_HELD_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && ah && lk_q[k]) |-> (a_rdata == DW'(1))); // R9

    AST_FREE_READ_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && ah && !lk_q[k]) |=> lk_q[k]); // R9

    AST_HELD_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_q[k] && !(a_wr && ah) && !(b_wr && bh)) |=> lk_q[k]); // R9

    AST_TIE_B_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && ah && b_rd && bh) |-> (b_rdata == DW'(1))); // R10
  end
endmodule

bind mbx_dir mbx_dir_chk #(.NCH(NCH), .AW(AW), .BASE(BASE)) u_dir_chk (
  .clk(clk), .rst_n(rst_n), .snd_wr(snd_wr), .snd_addr(snd_addr),
  .rcv_wr(rcv_wr), .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata),
  .st_q(st_q), .irq(irq)
);

bind mbx_locks mbx_lock_chk #(.NLK(NLK), .DW(DW), .AW(AW)) u_lock_chk (
  .clk(clk), .rst_n(rst_n), .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_addr),
  .b_rd(b_rd), .b_wr(b_wr), .b_addr(b_addr),
  .a_rdata(a_rdata), .b_rdata(b_rdata), .lk_q(lk_q)
);

// File: tb/tb_mbx_dual_top.sv
`timescale 1ns/1ps
module tb_mbx_dual_top;
  localparam int unsigned NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic a_psel, a_penable, a_pwrite, b_psel, b_penable, b_pwrite;
  logic [11:0] a_paddr, b_paddr;
  logic [31:0] a_pwdata, b_pwdata, a_prdata, b_prdata;
  logic [NCH-1:0] irq_a, irq_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] qa_exp[$];
  string       qa_tag[$];
  logic [31:0] qb_exp[$];
  string       qb_tag[$];

  always #2 clk = ~clk;

  mbx_dual_top dut (
    .clk(clk), .rst_n(rst_n),
    .a_psel(a_psel), .a_penable(a_penable), .a_pwrite(a_pwrite),
    .a_paddr(a_paddr), .a_pwdata(a_pwdata), .a_prdata(a_prdata),
    .b_psel(b_psel), .b_penable(b_penable), .b_pwrite(b_pwrite),
    .b_paddr(b_paddr), .b_pwdata(b_pwdata), .b_prdata(b_prdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // Driver tasks: reads push the expected value into the scoreboard
  task automatic wr_a(input logic [11:0] ad, input logic [31:0] d);
    @(posedge clk); #1 a_psel = 1; a_pwrite = 1; a_paddr = ad; a_pwdata = d;
    @(posedge clk); #1 a_penable = 1;
    @(posedge clk); #1 a_psel = 0; a_penable = 0;
  endtask
  task automatic rd_a(input logic [11:0] ad, input logic [31:0] ex, input string tg);
    qa_exp.push_back(ex); qa_tag.push_back(tg);
    @(posedge clk); #1 a_psel = 1; a_pwrite = 0; a_paddr = ad;
    @(posedge clk); #1 a_penable = 1;
    @(posedge clk); #1 a_psel = 0; a_penable = 0;
  endtask
  task automatic wr_b(input logic [11:0] ad, input logic [31:0] d);
    @(posedge clk); #1 b_psel = 1; b_pwrite = 1; b_paddr = ad; b_pwdata = d;
    @(posedge clk); #1 b_penable = 1;
    @(posedge clk); #1 b_psel = 0; b_penable = 0;
  endtask
  task automatic rd_b(input logic [11:0] ad, input logic [31:0] ex, input string tg);
    qb_exp.push_back(ex); qb_tag.push_back(tg);
    @(posedge clk); #1 b_psel = 1; b_pwrite = 0; b_paddr = ad;
    @(posedge clk); #1 b_penable = 1;
    @(posedge clk); #1 b_psel = 0; b_penable = 0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] ex, input string tg);
    checks++;
    if (got !== ex) begin
      fails++;
      $display("FAIL %s got %h expected %h", tg, got, ex);
    end
  endtask

  // Monitors: compare access-phase read data against the scoreboard
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (a_psel && a_penable && !a_pwrite) begin
      checks++;
      if (qa_exp.size() == 0) begin
        fails++; $display("FAIL R7 side A read with no expectation got %h expected none", a_prdata);
      end else begin
        e = qa_exp.pop_front(); t = qa_tag.pop_front();
        if (a_prdata !== e) begin
          fails++; $display("FAIL %s side A read got %h expected %h", t, a_prdata, e);
        end
      end
    end
    if (b_psel && b_penable && !b_pwrite) begin
      checks++;
      if (qb_exp.size() == 0) begin
        fails++; $display("FAIL R7 side B read with no expectation got %h expected none", b_prdata);
      end else begin
        e = qb_exp.pop_front(); t = qb_tag.pop_front();
        if (b_prdata !== e) begin
          fails++; $display("FAIL %s side B read got %h expected %h", t, b_prdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog run did not finish got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    a_psel = 0; a_penable = 0; a_pwrite = 0; a_paddr = '0; a_pwdata = '0;
    b_psel = 0; b_penable = 0; b_pwrite = 0; b_paddr = '0; b_pwdata = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    #1;

    // R1: reset state
    chk(32'(irq_a), 0, "R1 irq_a");
    chk(32'(irq_b), 0, "R1 irq_b");
    rd_b(12'h000, 0, "R1 a2b enable");
    rd_b(12'h004, 0, "R1 a2b status");
    rd_a(12'h008, 0, "R1 a2b cmd0");
    rd_a(12'h024, 0, "R1 a2b data3");
    rd_a(12'h02C, 0, "R1 b2a status");
    rd_a(12'h100, 0, "R1 lock0 free");

    // R3, R8, R7: command alone, then data
    wr_a(12'h010, 32'hC0DE0001);
    rd_b(12'h004, 0, "R3 cmd alone");
    wr_a(12'h014, 32'h12345678);
    rd_b(12'h004, 32'h2, "R3 data sets ch1");
    rd_b(12'h010, 32'hC0DE0001, "R8 cmd1 via B");
    rd_b(12'h014, 32'h12345678, "R8 data1 via B");
    rd_a(12'h014, 32'h12345678, "R7 data1 via A");

    // R5, R4, R6: enables and acknowledges
    chk(32'(irq_b), 0, "R5 disabled");
    wr_b(12'h000, 32'hF);
    chk(32'(irq_b), 32'h2, "R5 enabled ch1");
    wr_b(12'h004, 32'h0);
    rd_b(12'h004, 32'h2, "R4 write zero");
    wr_b(12'h004, 32'h1);
    rd_b(12'h004, 32'h2, "R4 clear other bit");
    wr_a(12'h004, 32'h2);
    rd_b(12'h004, 32'h2, "R6 A cannot clear a2b");
    chk(32'(irq_b), 32'h2, "R5 level held");
    wr_b(12'h004, 32'h2);
    rd_b(12'h004, 0, "R4 cleared");
    chk(32'(irq_b), 0, "R5 falls on clear");

    // R6: wrong-side writes
    wr_b(12'h018, 32'hDEAD);
    rd_a(12'h018, 0, "R6 B cannot write a2b cmd");
    wr_b(12'h01C, 32'hBEEF);
    rd_b(12'h004, 0, "R6 B data write sets nothing");
    rd_a(12'h01C, 0, "R6 B cannot write a2b data");
    wr_a(12'h000, 32'h0);
    rd_b(12'h000, 32'hF, "R6 A cannot write a2b enable");

    // B-to-A direction
    wr_a(12'h028, 32'hF);
    wr_b(12'h048, 32'h000000AA);
    chk(32'(irq_a), 0, "R3 b2a cmd alone");
    wr_b(12'h04C, 32'h00000055);
    chk(32'(irq_a), 32'h8, "R5 b2a ch3");
    rd_a(12'h02C, 32'h8, "R3 b2a status ch3");
    rd_a(12'h048, 32'hAA, "R2 b2a cmd3 offset");
    rd_b(12'h04C, 32'h55, "R7 b2a data3 via B");
    wr_a(12'h028, 32'h7);
    chk(32'(irq_a), 0, "R5 masked");
    rd_a(12'h02C, 32'h8, "R5 status kept while masked");
    wr_a(12'h028, 32'hF);
    chk(32'(irq_a), 32'h8, "R5 unmasked");
    wr_a(12'h02C, 32'h8);
    chk(32'(irq_a), 0, "R4 b2a cleared");

    // R4: set and clear collide
    wr_a(12'h00C, 32'h1);
    chk(32'(irq_b), 32'h1, "R3 ch0 set");
    fork
      wr_a(12'h00C, 32'h2);
      wr_b(12'h004, 32'h1);
    join
    rd_b(12'h004, 32'h1, "R4 set wins");
    wr_b(12'h004, 32'h1);
    rd_b(12'h004, 0, "R4 cleared after tie");

    // R9, R10: locks
    rd_a(12'h100, 32'h1, "R9 lock0 held A");
    rd_b(12'h100, 32'h1, "R9 lock0 held B");
    wr_b(12'h100, 32'h0);
    rd_a(12'h100, 0, "R9 released by B");
    wr_a(12'h100, 32'h1234);
    fork
      rd_a(12'h110, 0, "R10 A wins");
      rd_b(12'h110, 32'h1, "R10 B loses");
    join
    rd_b(12'h118, 0, "R9 lock3 free to B");
    rd_a(12'h118, 32'h1, "R9 lock3 held by B");

    // R11: unmapped offsets
    rd_a(12'h200, 0, "R11 far offset");
    rd_b(12'h050, 0, "R11 after b2a");
    rd_a(12'h006, 0, "R11 unaligned");
    wr_a(12'h11C, 32'hFFFFFFFF);
    rd_b(12'h118, 32'h1, "R11 gap write keeps lock");
    wr_b(12'h050, 32'hFFFFFFFF);
    rd_a(12'h02C, 0, "R11 gap write sets nothing");

    repeat (3) @(posedge clk);
    #1;
    chk(32'(qa_exp.size() + qb_exp.size()), 0, "R7 scoreboard drained");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule